// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small multicycle processor. It walks each instruction through a fixed series of states. Every instruction starts with a fetch cycle and a decode/operand-read cycle. After that, each of five instruction classes takes its own path: register-register ALU operations, OR with an immediate, word load, word store and branch-on-equal. Each state drives a fixed set of datapath strobes: register load enables, the ALU operation and operand source, the memory read and write, the register-file write with its destination and data source, and the PC update.

The opcode comes from the instruction register, and the sequencer looks at it only while in decode. An unrecognised opcode sends the sequencer back to fetch without any write. The equality flag is a datapath register that is loaded in decode. It is used only in the branch state, where it selects the branch target for the PC. Every other output depends on the current state alone.

The state code is a fixed 4-bit value and is visible on a port. Each instruction class has its own execute and completion states, and no execute state is shared between classes.

Top module: `mcc_top`

## Requirements
- R1: A synchronous, active-high `rst` puts the sequencer in fetch (state 0000) on the next clock. This holds in any state. While in fetch, only `imemRd` and `irEn` are high.
- R2: Fetch always goes to decode (0001). Decode drives `aEn`, `bEn` and `eEn` high with `aluSel`=11 (subtract for the compare) and `aluSrc`=00 (B register). No other strobe is high in decode.
- R3: For opcode 000000 (register-register), decode goes to 0100 and then to 0101. In 0100, `aluSel`=10 (function field), `aluSrc`=00 and `sEn` is high. In 0101, `regWr`, `regDst` (1 = rd) and `pcEn` are high.
- R4: For opcode 001101 (OR immediate), decode goes to 0110 and then to 0111. In 0110, `aluSel`=01 (OR), `aluSrc`=01 (zero-extended immediate) and `sEn` are set. In 0111, `regWr` and `pcEn` are high and `regDst` is 0 (rt).
- R5: For opcode 100011 (load), the path is 1000, then 1001, then 1010. In 1000, `aluSel`=00 (add), `aluSrc`=10 (sign-extended immediate) and `sEn` are set. In 1001, `dmemRd` and `mEn` are high. In 1010, `regWr`, `memToReg` and `pcEn` are high and `regDst` is 0.
- R6: For opcode 101011 (store), the path is 1011 and then 1100. State 1011 drives the same strobes as 1000. In 1100, `dmemWr` and `pcEn` are high.
- R7: For opcode 000100 (branch), decode goes to 0011. In 0011, `pcEn` is high and `pcBranch` equals `eqFlag`.
- R8: Any other opcode in decode returns the sequencer to fetch on the next clock, with no register, memory or PC write.
- R9: Counted from fetch to the next fetch, an instruction takes 4 cycles for register-register and OR immediate, 5 for load, 4 for store, 3 for branch and 2 for an unrecognised opcode.
- R10: Each completion state (0101, 0111, 1010, 1100, 0011) returns to fetch. `regWr` and `dmemWr` are never high together, and `pcEn` is high exactly once per instruction.
- R11: The value of `opcode` in any state other than decode has no effect on the state sequence or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| eqFlag | input | 1 | Registered operand-equality flag |
| imemRd | output | 1 | Instruction memory read |
| irEn | output | 1 | Instruction register load |
| aEn | output | 1 | A operand register load |
| bEn | output | 1 | B operand register load |
| eEn | output | 1 | Equality flag register load |
| aluSel | output | 2 | ALU op: 00 add, 01 or, 10 function field, 11 subtract |
| aluSrc | output | 2 | ALU second operand: 00 B, 01 zero-ext imm, 10 sign-ext imm |
| sEn | output | 1 | ALU result register load |
| dmemRd | output | 1 | Data memory read |
| dmemWr | output | 1 | Data memory write |
| mEn | output | 1 | Memory data register load |
| regWr | output | 1 | Register file write |
| regDst | output | 1 | Write destination: 1 rd, 0 rt |
| memToReg | output | 1 | Write data: 1 memory register, 0 ALU result register |
| pcEn | output | 1 | PC load |
| pcBranch | output | 1 | PC source: 1 branch target, 0 PC+4 |
| state | output | 4 | Current state code |

## Verification
The bench targets four kinds of faults:
- **Decode dispatch.** Each class is checked separately. A swapped dispatch would send a load down the store path, which shows up as a wrong state or as `dmemWr` where `regWr` was expected.
- **Unrecognised opcodes.** These include the jump code. A decoder that lets them fall into some path would raise a write or stretch the instruction past two cycles.
- **Stray opcodes outside decode.** The opcode changes on every cycle other than decode, so a sequencer that samples it outside decode would leave its expected path.
- **Branch select and mid-instruction reset.** Branch runs with the flag both set and clear, to catch a `pcBranch` that ignores or inverts the flag. A reset is applied in the middle of a load; one that did not take effect at once would let the write-back happen.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W  = 6;
  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;

  // fixed state assignment, one execute and one completion state per class
  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'b0000,
    ST_DECODE = 4'b0001,
    ST_BRANCH = 4'b0011,
    ST_R_EX   = 4'b0100,
    ST_R_WB   = 4'b0101,
    ST_O_EX   = 4'b0110,
    ST_O_WB   = 4'b0111,
    ST_L_EX   = 4'b1000,
    ST_L_MEM  = 4'b1001,
    ST_L_WB   = 4'b1010,
    ST_S_EX   = 4'b1011,
    ST_S_MEM  = 4'b1100
  } state_e;

  localparam logic [SEL_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [SEL_W-1:0] ALU_OR   = 2'b01;
  localparam logic [SEL_W-1:0] ALU_FUNC = 2'b10;
  localparam logic [SEL_W-1:0] ALU_SUB  = 2'b11;

  localparam logic [SEL_W-1:0] SRC_B  = 2'b00;
  localparam logic [SEL_W-1:0] SRC_ZX = 2'b01;
  localparam logic [SEL_W-1:0] SRC_SX = 2'b10;

  // strobe bundle from the sequencer to the datapath
  typedef struct packed {
    logic             imemRd;
    logic             irEn;
    logic             aEn;
    logic             bEn;
    logic             eEn;
    logic [SEL_W-1:0] aluSel;
    logic [SEL_W-1:0] aluSrc;
    logic             sEn;
    logic             dmemRd;
    logic             dmemWr;
    logic             mEn;
    logic             regWr;
    logic             regDst;
    logic             memToReg;
    logic             pcEn;
    logic             pcBranch;
  } ctrl_t;

  function automatic logic isKnownOp(input logic [OP_W-1:0] op);
    return (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LOAD) ||
           (op == OP_STORE) || (op == OP_BEQ);
  endfunction
endpackage

// File: rtl/mcc_state.sv
module mcc_state
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output state_e          stateQ
);
  state_e stateD;

  always_comb begin
    stateD = ST_FETCH;
    case (stateQ)
      ST_FETCH:  stateD = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_RTYPE: stateD = ST_R_EX;
          OP_ORI:   stateD = ST_O_EX;
          OP_LOAD:  stateD = ST_L_EX;
          OP_STORE: stateD = ST_S_EX;
          OP_BEQ:   stateD = ST_BRANCH;
          default:  stateD = ST_FETCH;
        endcase
      end
      ST_R_EX:  stateD = ST_R_WB;
      ST_O_EX:  stateD = ST_O_WB;
      ST_L_EX:  stateD = ST_L_MEM;
      ST_L_MEM: stateD = ST_L_WB;
      ST_S_EX:  stateD = ST_S_MEM;
      default:  stateD = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_FETCH;
    else     stateQ <= stateD;
  end

  a_r1_reset_to_fetch: assert property (@(posedge clk)
    rst |=> (stateQ == ST_FETCH));
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_FETCH) |=> (stateQ == ST_DECODE));
  a_r8_unknown_refetch: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DECODE && !isKnownOp(opcode)) |=> (stateQ == ST_FETCH));
  a_r10_terminal_return: assert property (@(posedge clk) disable iff (rst)
    (stateQ inside {ST_R_WB, ST_O_WB, ST_L_WB, ST_S_MEM, ST_BRANCH})
    |=> (stateQ == ST_FETCH));
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  state_e st,
  input  logic   eqFlag,
  output ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    case (st)
      ST_FETCH: begin
        ctrl.imemRd = 1'b1;
        ctrl.irEn   = 1'b1;
      end
      ST_DECODE: begin
        ctrl.aEn    = 1'b1;
        ctrl.bEn    = 1'b1;
        ctrl.eEn    = 1'b1;
        ctrl.aluSel = ALU_SUB;
        ctrl.aluSrc = SRC_B;
      end
      ST_R_EX: begin
        ctrl.aluSel = ALU_FUNC;
        ctrl.aluSrc = SRC_B;
        ctrl.sEn    = 1'b1;
      end
      ST_R_WB: begin
        ctrl.regWr  = 1'b1;
        ctrl.regDst = 1'b1;
        ctrl.pcEn   = 1'b1;
      end
      ST_O_EX: begin
        ctrl.aluSel = ALU_OR;
        ctrl.aluSrc = SRC_ZX;
        ctrl.sEn    = 1'b1;
      end
      ST_O_WB: begin
        ctrl.regWr = 1'b1;
        ctrl.pcEn  = 1'b1;
      end
      ST_L_EX, ST_S_EX: begin
        ctrl.aluSel = ALU_ADD;
        ctrl.aluSrc = SRC_SX;
        ctrl.sEn    = 1'b1;
      end
      ST_L_MEM: begin
        ctrl.dmemRd = 1'b1;
        ctrl.mEn    = 1'b1;
      end
      ST_L_WB: begin
        ctrl.regWr    = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.pcEn     = 1'b1;
      end
      ST_S_MEM: begin
        ctrl.dmemWr = 1'b1;
        ctrl.pcEn   = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.pcEn     = 1'b1;
        ctrl.pcBranch = eqFlag;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_top.sv
module mcc_top
  import mcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic             eqFlag,
  output logic             imemRd,
  output logic             irEn,
  output logic             aEn,
  output logic             bEn,
  output logic             eEn,
  output logic [SEL_W-1:0] aluSel,
  output logic [SEL_W-1:0] aluSrc,
  output logic             sEn,
  output logic             dmemRd,
  output logic             dmemWr,
  output logic             mEn,
  output logic             regWr,
  output logic             regDst,
  output logic             memToReg,
  output logic             pcEn,
  output logic             pcBranch,
  output logic [ST_W-1:0]  state
);
  state_e curState;
  ctrl_t  ctrl;

  mcc_state u_state (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .stateQ (curState)
  );

  mcc_decode u_decode (
    .st     (curState),
    .eqFlag (eqFlag),
    .ctrl   (ctrl)
  );

  assign state    = curState;
  assign imemRd   = ctrl.imemRd;
  assign irEn     = ctrl.irEn;
  assign aEn      = ctrl.aEn;
  assign bEn      = ctrl.bEn;
  assign eEn      = ctrl.eEn;
  assign aluSel   = ctrl.aluSel;
  assign aluSrc   = ctrl.aluSrc;
  assign sEn      = ctrl.sEn;
  assign dmemRd   = ctrl.dmemRd;
  assign dmemWr   = ctrl.dmemWr;
  assign mEn      = ctrl.mEn;
  assign regWr    = ctrl.regWr;
  assign regDst   = ctrl.regDst;
  assign memToReg = ctrl.memToReg;
  assign pcEn     = ctrl.pcEn;
  assign pcBranch = ctrl.pcBranch;

  a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regWr, dmemWr}));
  a_r10_pc_then_fetch: assert property (@(posedge clk) disable iff (rst)
    pcEn |=> (imemRd && irEn));
  a_r5_load_data_ready: assert property (@(posedge clk) disable iff (rst)
    memToReg |-> $past(dmemRd));
  a_r7_branch_select: assert property (@(posedge clk) disable iff (rst)
    pcBranch |-> (pcEn && eqFlag));
  a_r2_decode_loads: assert property (@(posedge clk) disable iff (rst)
    $rose(eEn) |-> $past(irEn));
endmodule

// File: tb/mcc_top_tb.sv
module mcc_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       eqFlag = 1'b0;
  logic imemRd, irEn, aEn, bEn, eEn, sEn, dmemRd, dmemWr, mEn;
  logic regWr, regDst, memToReg, pcEn, pcBranch;
  logic [1:0] aluSel, aluSrc;
  logic [3:0] state;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  mcc_top u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .eqFlag(eqFlag),
    .imemRd(imemRd), .irEn(irEn), .aEn(aEn), .bEn(bEn), .eEn(eEn),
    .aluSel(aluSel), .aluSrc(aluSrc), .sEn(sEn), .dmemRd(dmemRd),
    .dmemWr(dmemWr), .mEn(mEn), .regWr(regWr), .regDst(regDst),
    .memToReg(memToReg), .pcEn(pcEn), .pcBranch(pcBranch), .state(state)
  );

  // order: imemRd irEn aEn bEn eEn aluSel aluSrc sEn dmemRd dmemWr mEn regWr regDst memToReg pcEn pcBranch
  wire [17:0] obs = {imemRd, irEn, aEn, bEn, eEn, aluSel, aluSrc, sEn,
                     dmemRd, dmemWr, mEn, regWr, regDst, memToReg, pcEn, pcBranch};

  function automatic logic [17:0] mk(bit im, bit ir, bit a, bit b, bit e,
      logic [1:0] as, logic [1:0] sr, bit s, bit mr, bit mw, bit m,
      bit rw, bit rd, bit m2r, bit pc, bit pb);
    return {im, ir, a, b, e, as, sr, s, mr, mw, m, rw, rd, m2r, pc, pb};
  endfunction

  function automatic logic [17:0] expOut(logic [3:0] st, bit eq);
    case (st)
      4'b0000: return mk(1,1,0,0,0,2'b00,2'b00,0,0,0,0,0,0,0,0,0);
      4'b0001: return mk(0,0,1,1,1,2'b11,2'b00,0,0,0,0,0,0,0,0,0);
      4'b0100: return mk(0,0,0,0,0,2'b10,2'b00,1,0,0,0,0,0,0,0,0);
      4'b0101: return mk(0,0,0,0,0,2'b00,2'b00,0,0,0,0,1,1,0,1,0);
      4'b0110: return mk(0,0,0,0,0,2'b01,2'b01,1,0,0,0,0,0,0,0,0);
      4'b0111: return mk(0,0,0,0,0,2'b00,2'b00,0,0,0,0,1,0,0,1,0);
      4'b1000,
      4'b1011: return mk(0,0,0,0,0,2'b00,2'b10,1,0,0,0,0,0,0,0,0);
      4'b1001: return mk(0,0,0,0,0,2'b00,2'b00,0,1,0,1,0,0,0,0,0);
      4'b1010: return mk(0,0,0,0,0,2'b00,2'b00,0,0,0,0,1,0,1,1,0);
      4'b1100: return mk(0,0,0,0,0,2'b00,2'b00,0,0,1,0,0,0,0,1,0);
      4'b0011: return mk(0,0,0,0,0,2'b00,2'b00,0,0,0,0,0,0,0,1,eq);
      default: return 18'h3ffff;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] st);
    case (st)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0100, 4'b0101: return "R3";
      4'b0110, 4'b0111: return "R4";
      4'b1000, 4'b1001, 4'b1010: return "R5";
      4'b1011, 4'b1100: return "R6";
      4'b0011: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int pathLen(logic [5:0] op);
    case (op)
      6'b000000, 6'b001101, 6'b101011: return 4;
      6'b100011: return 5;
      6'b000100: return 3;
      default:   return 2;
    endcase
  endfunction

  function automatic logic [3:0] expState(logic [5:0] op, int idx);
    if (idx == 0) return 4'b0000;
    if (idx == 1) return 4'b0001;
    case (op)
      6'b000000: return (idx == 2) ? 4'b0100 : (idx == 3) ? 4'b0101 : 4'b0000;
      6'b001101: return (idx == 2) ? 4'b0110 : (idx == 3) ? 4'b0111 : 4'b0000;
      6'b100011: return (idx == 2) ? 4'b1000 : (idx == 3) ? 4'b1001 :
                        (idx == 4) ? 4'b1010 : 4'b0000;
      6'b101011: return (idx == 2) ? 4'b1011 : (idx == 3) ? 4'b1100 : 4'b0000;
      6'b000100: return (idx == 2) ? 4'b0011 : 4'b0000;
      default:   return 4'b0000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // entered and left at a negedge with the sequencer in fetch
  task automatic runInstr(logic [5:0] op, bit eq);
    int cyc;
    logic [3:0] es;
    cyc = 0;
    eqFlag = eq;
    while (cyc < 8) begin
      es = expState(op, cyc);
      chk((cyc >= 2) ? "R11 state" : "R2 state", {28'd0, state}, {28'd0, es});
      chk(tagOf(es), {14'd0, obs}, {14'd0, expOut(es, eq)});
      // real opcode only while in decode, stray values elsewhere (R11)
      opcode = (cyc == 1) ? op : 6'($urandom);
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (state == 4'b0000) break;
    end
    chk((pathLen(op) == 2) ? "R8 length" : "R9 length", cyc, pathLen(op));
  endtask

  initial begin
    logic [5:0] op;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R1 reset state", {28'd0, state}, 32'd0);
    chk("R1 reset outputs", {14'd0, obs}, {14'd0, expOut(4'b0000, 1'b0)});
    rst = 1'b0;

    // directed: each class, both branch outcomes, unknown codes
    runInstr(6'b000000, 1'b0);
    runInstr(6'b001101, 1'b1);
    runInstr(6'b100011, 1'b0);
    runInstr(6'b101011, 1'b1);
    runInstr(6'b000100, 1'b1);
    runInstr(6'b000100, 1'b0);
    runInstr(6'b000010, 1'b1);
    runInstr(6'b111111, 1'b0);

    // reset in the middle of a load: no write-back may follow (R1)
    eqFlag = 1'b0;
    opcode = 6'b100011;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R5 state before reset", {28'd0, state}, 32'h9);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid-run reset state", {28'd0, state}, 32'd0);
    chk("R1 mid-run reset outputs", {14'd0, obs}, {14'd0, expOut(4'b0000, 1'b0)});
    rst = 1'b0;

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: op = 6'b000000;
        1: op = 6'b001101;
        2: op = 6'b100011;
        3: op = 6'b101011;
        4: op = 6'b000100;
        default: begin
          op = 6'($urandom);
          if (pathLen(op) != 2 || op == 6'b000000) op = 6'b111110;
        end
      endcase
      runInstr(op, 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule